// File: doc/BRIEF.md
# Latch-or-Register Bus Driver

A 20-channel data driver for a shared bus. It can pass data straight through, capture the bus on a rising edge of a capture strobe, or hold its last value. One stored word per channel serves both the pass-through and the edge-capture behaviour. An active-low pass control picks between the two. An active-low output enable gates the whole bus. A pad wrapper above this block builds the tri-state pins from the data vector and the per-bit drive-enable vector.

The block runs on a system clock `clk`. The capture strobe `cap_stb` is a plain control input, sampled on `clk`, and a rising edge is detected between two samples. Data flows in and out as a plain level bus, not as a handshake stream. There is no valid/ready pair and no back-pressure: the outputs reflect the inputs and the stored word at all times. The asynchronous reset clears the stored word only. It leaves the output-enable path untouched.

Top module: `latchreg_bus_driver`

## Requirements
- R1: While `out_en_n` is 1, `dout` is all zeros and `drv_en` is all zeros, whatever the other inputs do.
- R2: While `out_en_n` is 0, `drv_en` is all ones on every channel, also during reset.
- R3: While `pass_n` is 0 and `out_en_n` is 0, `dout` equals `din` in the same cycle, with no clock edge needed.
- R4: While `pass_n` is 1, a `clk` edge that sees `cap_stb` at 1 after it was 0 at the previous `clk` edge stores `din`. The stored word appears on `dout` after that edge and not before it.
- R5: While `pass_n` is 1 and `cap_stb` stays steady (0 or 1), `dout` keeps its value when `din` changes.
- R6: At every `clk` edge where `pass_n` is 0, the stored word takes `din`. After `pass_n` returns to 1, `dout` shows the `din` seen at the last such edge. A strobe that rose while `pass_n` was 0 causes no capture when `pass_n` returns to 1 with `cap_stb` still at 1.
- R7: `rst_n` at 0 clears the stored word to zero at once. With `pass_n` at 1 and `out_en_n` at 0, `dout` then reads zero.
- R8: `out_en_n` never affects storage. Captures and pass-through updates made while the outputs are disabled appear on `dout` as soon as `out_en_n` returns to 0.
- R9: The edge detector's previous-strobe state resets to 1. As a result, `cap_stb` held at 1 through the release of reset captures nothing. All channels share the three controls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; samples the strobe and updates the stored word |
| rst_n | input | 1 | Asynchronous active-low reset of the stored word and edge detector |
| out_en_n | input | 1 | Active-low output enable for the whole bus |
| pass_n | input | 1 | Active-low pass-through select; 1 selects capture/hold |
| cap_stb | input | 1 | Capture strobe; a sampled rising edge stores the bus |
| din | input | 20 | Data inputs |
| dout | output | 20 | Data outputs (zero while disabled) |
| drv_en | output | 20 | Per-bit drive enable for the pad wrapper |

## Verification
The hardest case to reach is leaving pass-through while the strobe is already high. The strobe must rise during the pass-through phase, and `pass_n` must then return to 1 without the strobe falling. The stimulus builds this order on purpose and changes `din` in the same cycle as the exit, to show that only the last pass-through value is held. A strobe held high through the release of reset is driven in the same way. After the directed part, a pseudo-random sweep mixes all three controls against a reference model written from the requirements.

// File: rtl/bdrv_pkg.sv
package bdrv_pkg;
  localparam int unsigned BDRV_WIDTH = 20;

  typedef enum logic [1:0] {
    MODE_HOLD    = 2'd0,
    MODE_PASS    = 2'd1,
    MODE_CAPTURE = 2'd2
  } bdrv_mode_e;
endpackage

// File: rtl/bdrv_mode_ctl.sv
module bdrv_mode_ctl
  import bdrv_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pass_n,
  input  logic       cap_stb,
  output bdrv_mode_e mode
);
  logic stb_q;

  // previous strobe sample; resets high so a held strobe is not an edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stb_q <= 1'b1;
    else        stb_q <= cap_stb;
  end

  always_comb begin
    if (!pass_n)                mode = MODE_PASS;
    else if (cap_stb && !stb_q) mode = MODE_CAPTURE;
    else                        mode = MODE_HOLD;
  end

  // R6: a strobe that was already high is never a capture
  p_no_reedge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pass_n && cap_stb && $past(cap_stb)) |-> (mode == MODE_HOLD));
endmodule

// File: rtl/bdrv_store.sv
module bdrv_store
  import bdrv_pkg::*;
#(
  parameter int unsigned WIDTH = BDRV_WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  bdrv_mode_e       mode,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] store_q
);
  logic load;
  assign load = (mode != MODE_HOLD);

  for (genvar i = 0; i < WIDTH; i++) begin : g_chan
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    store_q[i] <= 1'b0;
      else if (load) store_q[i] <= din[i];
    end
  end

  // R4 / R6: loading modes take the bus
  p_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != MODE_HOLD) |=> (store_q == $past(din)));
  // R5: hold keeps the word
  p_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_HOLD) |=> $stable(store_q));
endmodule

// File: rtl/bdrv_out.sv
module bdrv_out
  import bdrv_pkg::*;
#(
  parameter int unsigned WIDTH = BDRV_WIDTH
) (
  input  logic             out_en_n,
  input  bdrv_mode_e       mode,
  input  logic [WIDTH-1:0] din,
  input  logic [WIDTH-1:0] store_q,
  output logic [WIDTH-1:0] dout,
  output logic [WIDTH-1:0] drv_en
);
  logic bypass;
  assign bypass = (mode == MODE_PASS);

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    always_comb begin
      drv_en[i] = ~out_en_n;
      if (out_en_n)    dout[i] = 1'b0;
      else if (bypass) dout[i] = din[i];
      else             dout[i] = store_q[i];
    end
  end
endmodule

// File: rtl/latchreg_bus_driver.sv
module latchreg_bus_driver
  import bdrv_pkg::*;
#(
  parameter int unsigned WIDTH = BDRV_WIDTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             out_en_n,
  input  logic             pass_n,
  input  logic             cap_stb,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic [WIDTH-1:0] drv_en
);
  bdrv_mode_e       mode;
  logic [WIDTH-1:0] store_q;

  bdrv_mode_ctl u_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .pass_n  (pass_n),
    .cap_stb (cap_stb),
    .mode    (mode)
  );

  bdrv_store #(.WIDTH(WIDTH)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .mode    (mode),
    .din     (din),
    .store_q (store_q)
  );

  bdrv_out #(.WIDTH(WIDTH)) u_out (
    .out_en_n (out_en_n),
    .mode     (mode),
    .din      (din),
    .store_q  (store_q),
    .dout     (dout),
    .drv_en   (drv_en)
  );

  p_off_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_en_n |-> (dout == '0 && drv_en == '0));
  p_on_drive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !out_en_n |-> (drv_en == '1));
  p_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!pass_n && !out_en_n) |-> (dout == din));
endmodule

// File: tb/latchreg_bus_driver_bench.sv
module latchreg_bus_driver_bench;
  localparam int W = 20;
  localparam logic [W-1:0] ONES = '1;

  typedef struct {
    string        tag;
    logic [W-1:0] exp_d;
    logic [W-1:0] exp_e;
  } sb_item_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         out_en_n = 1'b0;
  logic         pass_n = 1'b1;
  logic         cap_stb = 1'b0;
  logic [W-1:0] din = '0;
  logic [W-1:0] dout, drv_en;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  sb_item_t sb[$];

  // reference model state
  logic [W-1:0] m_store = '0;
  logic         m_prev = 1'b1;

  always #4 clk = ~clk;

  latchreg_bus_driver #(.WIDTH(W)) u_latchreg_bus_driver (
    .clk(clk), .rst_n(rst_n), .out_en_n(out_en_n), .pass_n(pass_n),
    .cap_stb(cap_stb), .din(din), .dout(dout), .drv_en(drv_en));

  // monitor: pops expectations and compares against the ports
  initial begin
    forever begin
      sb_item_t it;
      wait (sb.size() != 0);
      it = sb.pop_front();
      checks++;
      if (dout !== it.exp_d || drv_en !== it.exp_e) begin
        errors++;
        $display("FAIL %s: dout=%h drv_en=%h expected dout=%h drv_en=%h",
                 it.tag, dout, drv_en, it.exp_d, it.exp_e);
      end
    end
  end

  // advance to the next falling edge, update the model for the rising edge
  // just passed, then apply new inputs
  task automatic set(input logic oe, input logic ps, input logic st,
                     input logic [W-1:0] d);
    @(negedge clk);
    if (!rst_n) begin
      m_store = '0; m_prev = 1'b1;
    end else begin
      if (!pass_n)                 m_store = din;
      else if (cap_stb && !m_prev) m_store = din;
      m_prev = cap_stb;
    end
    out_en_n = oe; pass_n = ps; cap_stb = st; din = d;
    #1;
  endtask

  task automatic chk(input string tag, input logic [W-1:0] ed,
                     input logic [W-1:0] ee);
    sb_item_t it;
    it.tag = tag; it.exp_d = ed; it.exp_e = ee;
    sb.push_back(it);
    #1;
  endtask

  task automatic chk_model(input string tag);
    logic [W-1:0] ed;
    ed = out_en_n ? '0 : (!pass_n ? din : m_store);
    chk(tag, ed, out_en_n ? '0 : ONES);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    // reset state, strobe held high through reset
    set(0, 1, 1, 20'h12345);
    chk("R7 reset clears word", '0, ONES);
    chk("R2 drive enabled during reset", '0, ONES);
    @(negedge clk); rst_n = 1'b1; #1;
    set(0, 1, 1, 20'h12345);
    chk("R9 no capture from held strobe", '0, ONES);
    set(0, 1, 1, 20'h22222);
    chk("R9 still no capture", '0, ONES);

    // edge capture and hold
    set(0, 1, 0, 20'hABCDE);
    chk("R5 hold with strobe low", '0, ONES);
    set(0, 1, 1, 20'hABCDE);
    chk("R4 not visible before edge", '0, ONES);
    set(0, 1, 1, 20'h11111);
    chk("R4 captured after edge", 20'hABCDE, ONES);
    set(0, 1, 1, 20'h33333);
    chk("R5 hold with strobe high", 20'hABCDE, ONES);
    set(0, 1, 0, 20'h44444);
    chk("R5 hold after strobe fall", 20'hABCDE, ONES);

    // pass-through, strobe rises inside it, exit with strobe high
    set(0, 0, 0, 20'h55555);
    chk("R3 pass-through", 20'h55555, ONES);
    set(0, 0, 1, 20'hAAAAA);
    chk("R3 pass-through alt", 20'hAAAAA, ONES);
    set(0, 0, 1, 20'h0F0F0);
    chk("R3 pass-through new", 20'h0F0F0, ONES);
    set(0, 1, 1, 20'hFFFFF);
    chk("R6 exit with strobe high holds last pass value", 20'h0F0F0, ONES);
    set(0, 1, 1, 20'h00001);
    chk("R6 no late capture", 20'h0F0F0, ONES);

    // pass-through exit with strobe low, then real edge
    set(0, 0, 0, 20'h76543);
    chk("R3 pass-through again", 20'h76543, ONES);
    set(0, 1, 0, 20'h98765);
    chk("R6 exit with strobe low holds", 20'h76543, ONES);
    set(0, 1, 1, 20'h98765);
    chk("R6 holds until edge", 20'h76543, ONES);
    set(0, 1, 1, 20'h00000);
    chk("R4 capture after exit", 20'h98765, ONES);

    // outputs disabled; storage keeps working
    set(1, 1, 0, 20'hC0FFE);
    chk("R1 disabled", '0, '0);
    set(1, 1, 1, 20'hC0FFE);
    set(1, 1, 1, 20'h13579);
    chk("R1 disabled during capture", '0, '0);
    set(0, 1, 1, 20'h13579);
    chk("R8 capture while disabled shows", 20'hC0FFE, ONES);
    set(1, 0, 0, 20'hBEEF1);
    chk("R1 disabled during pass-through", '0, '0);
    set(0, 1, 0, 20'h2468A);
    chk("R8 pass value while disabled shows", 20'hBEEF1, ONES);

    // reset mid-run
    @(negedge clk); rst_n = 1'b0; #1;
    chk("R7 async reset clears", '0, ONES);
    set(0, 1, 0, 20'h2468A);
    @(negedge clk); rst_n = 1'b1; #1;
    chk("R7 after reset still zero", '0, ONES);

    // pseudo-random sweep against the model, shared controls on all channels
    lfsr = 32'hACE1_2B37;
    for (int k = 0; k < 400; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      set(lfsr[3:2] == 2'b11, lfsr[5], lfsr[7], lfsr[W+7:8]);
      chk_model("R9 sweep");
    end

    wait (sb.size() == 0);
    #1;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule